// File: doc/BRIEF.md
# PCI Configuration Access Register Unit

This block is a memory-mapped register front end through which a host processor performs configuration reads and writes on a PCI bus, and also reaches the bridge's own local configuration registers. Software first programs a target address register and a command register that holds the command code and the active-low byte enables. It then touches a data register. Writing a write-data register posts one transaction. Reading a read-data register stalls the host until the bus side responds. Both kinds of access leave the unit on a simple request/response port.

The unit keeps two error records, one for faults reported by the bus side and one for host accesses to offsets that decode to nothing. Each record holds status bits and the address of the first fault. Software clears the status bits by writing ones. Byte enables and lane-aligned write data pass through unchanged. Type 0 or type 1 address formation is done by software and forwarded exactly as written.

Top module: `cfgx_access_unit`

## Requirements
- R1: After synchronous reset every readable register reads 0, both error statuses are 0 and `bus_req` is low.
- R2: Word offsets 0x00 (local control), 0x04 (local write data), 0x0C (config address), 0x10 (config command) and 0x14 (config write data) read back the last value written to them.
- R3: A write to 0x14 while no transaction is pending is accepted in the same cycle. It then issues one bus write with `bus_local`=0, `bus_addr` = config address, `bus_cmd` = command bits [3:0] (0xB writes, 0xA reads), `bus_be_n` = command bits [7:4] and `bus_wdata` = the written word.
- R4: A read of 0x18 holds `hst_ready` low for at least two cycles. It issues one bus read with the same address, command and byte-enable fields, and returns the full response dword.
- R5: A write to 0x04 issues a local bus write only when local control bit 16 is 1. The local write carries `bus_be_n` = control bits [23:20] and `bus_addr` = control bits [LOC_OFF_W-1:2] with bits [1:0] zero. When bit 16 is 0 the data is only stored and no bus cycle occurs.
- R6: A read of 0x08 issues a local bus read with the same address and byte-enable fields and returns the response dword.
- R7: A response with `bus_err` bit 0 (master abort) or bit 1 (target abort) sets the same bit of the bus error status at 0x1C. A read that ends this way returns 0xFFFFFFFF.
- R8: An error address (0x20 for bus faults, 0x28 for host faults) is loaded only when its status has no bit left set after that cycle's clear. Otherwise the first fault address is kept.
- R9: Writing ones to 0x1C or 0x24 clears those status bits and zeros leave bits unchanged. A new fault in the same cycle as a clear leaves its bit set.
- R10: A host access to an unaligned offset or to an offset above 0x28 sets host error status bit 0 and captures the offset. Such a read returns 0 and such a write changes no register.
- R11: `bus_req` and all transaction fields stay constant until `bus_rsp`, and drop in the cycle after it. Any access that would start a transaction waits while one is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access request, held until ready |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | HADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | Host access completes this cycle |
| hst_rdata | output | 32 | Host read data, valid with ready |
| bus_req | output | 1 | Transaction pending toward the bus |
| bus_local | output | 1 | Transaction targets the bridge's own registers |
| bus_write | output | 1 | Transaction is a write |
| bus_cmd | output | 4 | Configuration command code |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_rsp | input | 1 | Transaction response this cycle |
| bus_err | input | 2 | Response fault: bit 0 master abort, bit 1 target abort |
| bus_rdata | input | 32 | Response read dword |

## Verification
A posted configuration write may draw a faulting response in the very cycle that software writes a one to clear the same bus error bit. The bench provokes this by giving the bus model zero latency and issuing the clear immediately after the posted write. It then judges the outcome by reading back status and error address: the bit must remain set, and the address must hold the new fault's address because the record was freed by the clear. Random configuration and local traffic with occasional faults checks the forwarded fields and returned data against values the bench computes.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int DW         = 32;
    localparam int CMD_W      = 4;
    localparam int BE_W       = 4;
    localparam int BERR_W     = 2;
    localparam int HERR_W     = 1;
    localparam int LOC_WR_BIT = 16;
    localparam int LOC_BE_LSB = 20;
    localparam int CFG_BE_LSB = 4;
    localparam int LAST_WORD  = 10;
    localparam logic [DW-1:0] FLOAT_BUS = '1;

    // word index order is decoded by software, so it is kept
    typedef enum logic [3:0] {
        SEL_LCTL = 4'd0, SEL_LWD = 4'd1, SEL_LRD = 4'd2,
        SEL_CADR = 4'd3, SEL_CCMD = 4'd4, SEL_CWD = 4'd5, SEL_CRD = 4'd6,
        SEL_BST = 4'd7, SEL_BADR = 4'd8, SEL_HST = 4'd9, SEL_HADR = 4'd10,
        SEL_NONE = 4'd15
    } reg_sel_e;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DONE} seq_st_e;

    typedef struct packed {
        logic             is_local;
        logic             write;
        logic [CMD_W-1:0] cmd;
        logic [BE_W-1:0]  be_n;
        logic [DW-1:0]    addr;
        logic [DW-1:0]    wdata;
    } bus_txn_t;

    function automatic reg_sel_e sel_of(input logic [DW-1:0] off);
        if (off[1:0] != 2'b00 || off[DW-1:2] > 30'(LAST_WORD))
            return SEL_NONE;
        return reg_sel_e'(off[5:2]);
    endfunction
endpackage

// File: rtl/cfgx_regfile.sv
module cfgx_regfile
    import cfgx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] loc_ctl,
    output logic [DW-1:0] loc_wdat,
    output logic [DW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_cmd,
    output logic [DW-1:0] cfg_wdat
);
    localparam int NREG = 5;
    localparam reg_sel_e SLOT [NREG] = '{SEL_LCTL, SEL_LWD, SEL_CADR, SEL_CCMD, SEL_CWD};

    logic [DW-1:0] store [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (wr_en && wr_sel == SLOT[g])
                store[g] <= wr_data;
        end
    end

    assign loc_ctl  = store[0];
    assign loc_wdat = store[1];
    assign cfg_addr = store[2];
    assign cfg_cmd  = store[3];
    assign cfg_wdat = store[4];
endmodule

// File: rtl/cfgx_txn_seq.sv
module cfgx_txn_seq
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  bus_txn_t          launch_txn,
    output logic              busy,
    output logic              rd_done,
    output logic [DW-1:0]     rd_data,
    output logic              bus_req,
    output bus_txn_t          bus_txn,
    input  logic              bus_rsp,
    input  logic [BERR_W-1:0] bus_err,
    input  logic [DW-1:0]     bus_rdata,
    output logic [BERR_W-1:0] evt_err,
    output logic [DW-1:0]     evt_addr
);
    seq_st_e       st;
    bus_txn_t      txn_q;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            txn_q <= '0;
            rd_q  <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (launch) begin
                    txn_q <= launch_txn;
                    st    <= SQ_WAIT;
                end
                SQ_WAIT: if (bus_rsp) begin
                    if (txn_q.write) begin
                        st <= SQ_IDLE;
                    end else begin
                        st   <= SQ_DONE;
                        rd_q <= (|bus_err) ? FLOAT_BUS : bus_rdata;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy     = (st != SQ_IDLE);
    assign rd_done  = (st == SQ_DONE);
    assign rd_data  = rd_q;
    assign bus_req  = (st == SQ_WAIT);
    assign bus_txn  = txn_q;
    assign evt_err  = (bus_req && bus_rsp) ? bus_err : '0;
    assign evt_addr = txn_q.addr;

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_rsp |=> bus_req && $stable(bus_txn));
    p_drop_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_rsp |=> !bus_req);
    p_float_r7: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_rsp && (|bus_err) && !bus_txn.write |=> rd_done && rd_data == FLOAT_BUS);
endmodule

// File: rtl/cfgx_err_log.sv
module cfgx_err_log #(
    parameter int W  = 1,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  set,
    input  logic [AW-1:0] set_addr,
    input  logic          clr_en,
    input  logic [W-1:0]  clr_mask,
    output logic [W-1:0]  status,
    output logic [AW-1:0] addr
);
    logic [W-1:0] eff_clr;
    logic [W-1:0] kept;
    logic         free;

    assign eff_clr = clr_en ? clr_mask : '0;
    assign kept    = status & ~eff_clr;
    assign free    = (kept == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            addr   <= '0;
        end else begin
            status <= kept | set;
            if ((|set) && free)
                addr <= set_addr;
        end
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> (status & $past(set)) == $past(set));
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        clr_en && !(|set) |=> (status & $past(eff_clr)) == '0);
    p_addr_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !free |=> addr == $past(addr));
endmodule

// File: rtl/cfgx_access_unit.sv
module cfgx_access_unit
    import cfgx_pkg::*;
#(
    parameter int HADDR_W   = 8,
    parameter int LOC_OFF_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic               hst_ready,
    output logic [31:0]        hst_rdata,
    output logic               bus_req,
    output logic               bus_local,
    output logic               bus_write,
    output logic [3:0]         bus_cmd,
    output logic [3:0]         bus_be_n,
    output logic [31:0]        bus_addr,
    output logic [31:0]        bus_wdata,
    input  logic               bus_rsp,
    input  logic [1:0]         bus_err,
    input  logic [31:0]        bus_rdata
);
    localparam int OFF_PAD = DW - HADDR_W;
    localparam int LOC_PAD = DW - LOC_OFF_W;

    logic [DW-1:0]     off;
    reg_sel_e          sel;
    logic [DW-1:0]     loc_ctl, loc_wdat, cfg_addr, cfg_cmd, cfg_wdat;
    logic              busy, rd_done, launch, trig_w, trig_r, acc, wr_acc, to_local;
    logic [DW-1:0]     rd_data, evt_addr;
    logic [BERR_W-1:0] evt_err, bst;
    logic [HERR_W-1:0] hst_st;
    logic [DW-1:0]     badr, hadr;
    bus_txn_t          launch_txn, txn;

    assign off = {{OFF_PAD{1'b0}}, hst_addr};
    assign sel = sel_of(off);

    assign trig_w = hst_we && (sel == SEL_CWD || (sel == SEL_LWD && loc_ctl[LOC_WR_BIT]));
    assign trig_r = !hst_we && (sel == SEL_CRD || sel == SEL_LRD);

    always_comb begin
        if (!hst_req)    hst_ready = 1'b0;
        else if (trig_w) hst_ready = !busy;
        else if (trig_r) hst_ready = rd_done;
        else             hst_ready = 1'b1;
    end

    assign launch = hst_req && !busy && (trig_w || trig_r);
    assign acc    = hst_req && hst_ready;
    assign wr_acc = acc && hst_we;

    assign to_local = (sel == SEL_LWD || sel == SEL_LRD);
    always_comb begin
        launch_txn.is_local = to_local;
        launch_txn.write    = hst_we;
        launch_txn.cmd      = to_local ? '0 : cfg_cmd[CMD_W-1:0];
        launch_txn.be_n     = to_local ? loc_ctl[LOC_BE_LSB +: BE_W] : cfg_cmd[CFG_BE_LSB +: BE_W];
        launch_txn.addr     = to_local ? {LOC_PAD'(0), loc_ctl[LOC_OFF_W-1:2], 2'b00} : cfg_addr;
        launch_txn.wdata    = hst_wdata;
    end

    cfgx_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_acc), .wr_sel(sel), .wr_data(hst_wdata),
        .loc_ctl(loc_ctl), .loc_wdat(loc_wdat), .cfg_addr(cfg_addr),
        .cfg_cmd(cfg_cmd), .cfg_wdat(cfg_wdat)
    );

    cfgx_txn_seq u_seq (
        .clk(clk), .rst(rst), .launch(launch), .launch_txn(launch_txn),
        .busy(busy), .rd_done(rd_done), .rd_data(rd_data),
        .bus_req(bus_req), .bus_txn(txn),
        .bus_rsp(bus_rsp), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .evt_err(evt_err), .evt_addr(evt_addr)
    );

    cfgx_err_log #(.W(BERR_W), .AW(DW)) u_bus_err (
        .clk(clk), .rst(rst), .set(evt_err), .set_addr(evt_addr),
        .clr_en(wr_acc && sel == SEL_BST), .clr_mask(hst_wdata[BERR_W-1:0]),
        .status(bst), .addr(badr)
    );

    cfgx_err_log #(.W(HERR_W), .AW(DW)) u_hst_err (
        .clk(clk), .rst(rst), .set({HERR_W{acc && sel == SEL_NONE}}), .set_addr(off),
        .clr_en(wr_acc && sel == SEL_HST), .clr_mask(hst_wdata[HERR_W-1:0]),
        .status(hst_st), .addr(hadr)
    );

    assign bus_local = txn.is_local;
    assign bus_write = txn.write;
    assign bus_cmd   = txn.cmd;
    assign bus_be_n  = txn.be_n;
    assign bus_addr  = txn.addr;
    assign bus_wdata = txn.wdata;

    always_comb begin
        case (sel)
            SEL_LCTL:         hst_rdata = loc_ctl;
            SEL_LWD:          hst_rdata = loc_wdat;
            SEL_CADR:         hst_rdata = cfg_addr;
            SEL_CCMD:         hst_rdata = cfg_cmd;
            SEL_CWD:          hst_rdata = cfg_wdat;
            SEL_LRD, SEL_CRD: hst_rdata = rd_data;
            SEL_BST:          hst_rdata = {{(DW-BERR_W){1'b0}}, bst};
            SEL_BADR:         hst_rdata = badr;
            SEL_HST:          hst_rdata = {{(DW-HERR_W){1'b0}}, hst_st};
            SEL_HADR:         hst_rdata = hadr;
            default:          hst_rdata = '0;
        endcase
    end

    p_host_err_r10: assert property (@(posedge clk) disable iff (rst)
        hst_req && sel == SEL_NONE |=> hst_st[0]);
    p_stall_busy_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && hst_req && trig_w |-> !hst_ready);
endmodule

// File: tb/test_cfgx_access_unit.sv
`timescale 1ns/1ps
module test_cfgx_access_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ready;
    logic [31:0] hst_rdata;
    logic        bus_req, bus_local, bus_write;
    logic [3:0]  bus_cmd, bus_be_n;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_rsp;
    logic [1:0]  bus_err;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    cfgx_access_unit i_cfgx_access_unit (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ready(hst_ready), .hst_rdata(hst_rdata),
        .bus_req(bus_req), .bus_local(bus_local), .bus_write(bus_write), .bus_cmd(bus_cmd),
        .bus_be_n(bus_be_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rsp(bus_rsp), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int fix_lat = -1;
    logic [1:0]  inj_err = 2'b00;
    logic [31:0] rsp_data = '0;
    int          obs_cnt = 0;
    logic        obs_local, obs_write;
    logic [3:0]  obs_cmd, obs_be;
    logic [31:0] obs_addr, obs_wdata;
    logic [31:0] rd;
    int          w;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus responder
    initial begin
        int lat;
        bus_rsp = 1'b0; bus_err = 2'b00; bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_rsp) begin
                bus_rsp = 1'b0; bus_err = 2'b00;
            end else if (bus_req) begin
                lat = (fix_lat >= 0) ? fix_lat : int'($urandom_range(0, 3));
                repeat (lat) @(negedge clk);
                obs_local = bus_local; obs_write = bus_write; obs_cmd = bus_cmd;
                obs_be = bus_be_n; obs_addr = bus_addr; obs_wdata = bus_wdata;
                obs_cnt++;
                bus_rsp = 1'b1; bus_err = inj_err; bus_rdata = rsp_data;
            end
        end
    end

    // called at a negedge, returns at a negedge with the request dropped
    task automatic acc(input bit we, input logic [7:0] a, input logic [31:0] d);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
        w = 0;
        #1;
        while (!hst_ready) begin
            @(negedge clk); #1; w++;
        end
        rd = hst_rdata;
        @(posedge clk);
        @(negedge clk);
        hst_req = 1'b0;
    endtask

    task automatic wait_obs(input int start);
        for (int k = 0; k < 20 && obs_cnt == start; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R11 actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic [31:0] a, c, d, cm, ctl, bA;
        int n0, op;
        logic [1:0] e;
        void'($urandom(32'hC0F1));
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        chk(bus_req == 1'b0, "R1 bus_req", {31'd0, bus_req}, 0);
        foreach (a[i]) if (i <= 10 && i != 2 && i != 6) begin
            acc(0, 8'(i * 4), 0);
            chk(rd == 0, $sformatf("R1 reg 0x%0h", i * 4), rd, 0);
        end

        // R2 and R5 (bit 16 clear: store only)
        ctl = $urandom() & ~32'h0001_0000;
        acc(1, 8'h00, ctl); acc(0, 8'h00, 0); chk(rd == ctl, "R2 local ctl", rd, ctl);
        a = $urandom(); acc(1, 8'h0C, a); acc(0, 8'h0C, 0); chk(rd == a, "R2 cfg addr", rd, a);
        cm = {$urandom_range(0, 255), 16'h0, 4'h3, 4'hB};
        acc(1, 8'h10, cm); acc(0, 8'h10, 0); chk(rd == cm, "R2 cfg cmd", rd, cm);
        n0 = obs_cnt; d = $urandom();
        acc(1, 8'h04, d); repeat (8) @(negedge clk);
        chk(obs_cnt == n0, "R5 no local write when bit16 clear", obs_cnt, n0);
        acc(0, 8'h04, 0); chk(rd == d, "R2 local wdata", rd, d);

        // R3 posted cfg write
        n0 = obs_cnt; d = $urandom();
        acc(1, 8'h14, d);
        chk(w == 0, "R3 posted accept", w, 0);
        wait_obs(n0);
        chk(obs_cnt == n0 + 1 && obs_write && !obs_local, "R3 write issued", {obs_write, obs_local}, 2'b10);
        chk(obs_addr == a, "R3 addr", obs_addr, a);
        chk(obs_cmd == 4'hB && obs_be == 4'h3, "R3 cmd/be", {obs_cmd, obs_be}, 8'hB3);
        chk(obs_wdata == d, "R3 wdata", obs_wdata, d);
        acc(0, 8'h14, 0); chk(rd == d, "R2 cfg wdata", rd, d);

        // R4 cfg read
        cm = 32'h0000_00CA; acc(1, 8'h10, cm);
        rsp_data = $urandom(); fix_lat = 0;
        acc(0, 8'h18, 0);
        chk(w >= 2, "R4 stall", w, 2);
        chk(rd == rsp_data, "R4 data", rd, rsp_data);
        chk(!obs_write && obs_cmd == 4'hA && obs_be == 4'hC && obs_addr == a, "R4 fields",
            {obs_write, obs_cmd, obs_be}, {1'b0, 4'hA, 4'hC});

        // R6 local read
        ctl = 32'h00E0_00B7; acc(1, 8'h00, ctl);
        rsp_data = $urandom(); fix_lat = -1;
        acc(0, 8'h08, 0);
        chk(rd == rsp_data, "R6 data", rd, rsp_data);
        chk(obs_local && !obs_write && obs_be == 4'hE && obs_addr == 32'hB4, "R6 fields",
            obs_addr, 32'hB4);

        // R5 local write with bit 16 set
        ctl = 32'h0071_0048; acc(1, 8'h00, ctl);
        n0 = obs_cnt; d = $urandom();
        acc(1, 8'h04, d); wait_obs(n0);
        chk(obs_local && obs_write && obs_be == 4'h7 && obs_addr == 32'h48 && obs_wdata == d,
            "R5 local write", obs_wdata, d);

        // R11 back-to-back posted writes stall the second
        fix_lat = 3; n0 = obs_cnt;
        acc(1, 8'h14, 32'h1111_1111);
        acc(1, 8'h14, 32'h2222_2222);
        chk(w >= 1, "R11 second write stalled", w, 1);
        wait_obs(n0 + 1);
        chk(obs_cnt == n0 + 2 && obs_wdata == 32'h2222_2222, "R11 both issued in order", obs_wdata, 32'h2222_2222);
        fix_lat = -1;

        // R7 / R8 / R9 error capture
        bA = 32'h0001_0800; acc(1, 8'h0C, bA);
        inj_err = 2'b01; acc(0, 8'h18, 0); inj_err = 2'b00;
        chk(rd == 32'hFFFF_FFFF, "R7 master abort data", rd, 32'hFFFF_FFFF);
        acc(0, 8'h1C, 0); chk(rd == 1, "R7 status bit0", rd, 1);
        acc(0, 8'h20, 0); chk(rd == bA, "R8 first addr", rd, bA);
        c = 32'h0002_1901; acc(1, 8'h0C, c);
        inj_err = 2'b10; acc(0, 8'h18, 0); inj_err = 2'b00;
        chk(rd == 32'hFFFF_FFFF, "R7 target abort data", rd, 32'hFFFF_FFFF);
        acc(0, 8'h1C, 0); chk(rd == 3, "R7 status both", rd, 3);
        acc(0, 8'h20, 0); chk(rd == bA, "R8 addr preserved", rd, bA);
        acc(1, 8'h1C, 0); acc(0, 8'h1C, 0); chk(rd == 3, "R9 zero write no effect", rd, 3);
        acc(1, 8'h1C, 2); acc(0, 8'h1C, 0); chk(rd == 1, "R9 clear bit1", rd, 1);
        // collision: clear of bit0 in the cycle a new bit0 fault lands
        fix_lat = 0; inj_err = 2'b01;
        acc(1, 8'h0C, c);
        acc(1, 8'h14, 32'h5A5A_5A5A);
        acc(1, 8'h1C, 1);
        inj_err = 2'b00; fix_lat = -1;
        repeat (2) @(negedge clk);
        acc(0, 8'h1C, 0); chk(rd == 1, "R9 set wins over clear", rd, 1);
        acc(0, 8'h20, 0); chk(rd == c, "R8 addr reloaded when freed", rd, c);
        acc(1, 8'h1C, 3); acc(0, 8'h1C, 0); chk(rd == 0, "R9 cleared", rd, 0);

        // R10 host errors
        acc(0, 8'h01, 0); chk(rd == 0, "R10 bad read data", rd, 0);
        acc(0, 8'h24, 0); chk(rd == 1, "R10 host status", rd, 1);
        acc(0, 8'h28, 0); chk(rd == 1, "R10 host addr", rd, 1);
        acc(1, 8'h30, 32'hDEAD_BEEF);
        acc(0, 8'h28, 0); chk(rd == 1, "R8 host addr preserved", rd, 1);
        acc(0, 8'h0C, 0); chk(rd == c, "R10 bad write no effect", rd, c);
        acc(1, 8'h24, 1); acc(0, 8'h24, 0); chk(rd == 0, "R9 host clear", rd, 0);
        acc(1, 8'h2C, 0); acc(0, 8'h28, 0); chk(rd == 32'h2C, "R10 new host addr", rd, 32'h2C);
        acc(1, 8'h24, 1);

        // random traffic
        for (int it = 0; it < 200; it++) begin
            op = int'($urandom_range(0, 2));
            e  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            a  = $urandom();
            cm = {24'h0, 4'($urandom()), (op == 0) ? 4'hB : 4'hA};
            ctl = $urandom();
            d  = $urandom();
            rsp_data = $urandom();
            acc(1, 8'h0C, a); acc(1, 8'h10, cm); acc(1, 8'h00, ctl);
            n0 = obs_cnt; inj_err = e;
            if (op == 0) begin
                acc(1, 8'h14, d); wait_obs(n0);
                chk(obs_write && !obs_local && obs_addr == a && obs_wdata == d &&
                    obs_cmd == cm[3:0] && obs_be == cm[7:4], "R3 random write", obs_wdata, d);
            end else if (op == 1) begin
                acc(0, 8'h18, 0);
                chk(rd == (e != 0 ? 32'hFFFF_FFFF : rsp_data), "R4 random read", rd,
                    e != 0 ? 32'hFFFF_FFFF : rsp_data);
                chk(!obs_write && obs_addr == a && obs_be == cm[7:4], "R4 random fields", obs_addr, a);
            end else begin
                acc(0, 8'h08, 0);
                chk(rd == (e != 0 ? 32'hFFFF_FFFF : rsp_data), "R6 random read", rd,
                    e != 0 ? 32'hFFFF_FFFF : rsp_data);
                chk(obs_local && obs_be == ctl[23:20] && obs_addr == {24'h0, ctl[7:2], 2'b00},
                    "R6 random fields", obs_addr, {24'h0, ctl[7:2], 2'b00});
            end
            inj_err = 2'b00;
            acc(0, 8'h1C, 0); chk(rd == {30'd0, e}, "R7 random status", rd, {30'd0, e});
            if (e != 0) begin
                acc(0, 8'h20, 0);
                chk(rd == obs_addr, "R8 random addr", rd, obs_addr);
                acc(1, 8'h1C, 3);
            end
        end

        summary();
    end
endmodule